// File: doc/BRIEF.md
# Per-Thread Issue Queue Share Limiter

This block limits how many entries of a shared instruction issue queue each hardware thread may occupy. It keeps one occupancy counter for each thread and a global free-entry counter. It works out a cap for each thread from one of three sharing policies and reports, every cycle, how many entries each thread may still claim and whether each thread, or the whole queue, is full. The block does not hold the queue storage and does not select instructions.

Each cycle the dispatch side raises an allocate pulse for every thread that wants an entry, and the issue or commit side raises a release pulse for every thread that frees one. Allocate pulses are granted in thread-index order, lowest index first, until either the thread's own headroom or the global headroom runs out. A pulse that is not granted is flagged back in the same cycle. The active-thread mask is registered, so caps that depend on it change one clock after the mask changes.

Top module: `iq_share_limiter`

## Requirements
- R1: Policy code 0 (dynamic) and the spare code 3 give every thread a cap equal to ENTRIES.
- R2: Under policy code 1 (partition), each thread set in the registered mask gets a cap of ENTRIES divided by the number of set bits, truncated. A thread that is not set, or every thread when no bit is set, gets ENTRIES divided by NUM_THR.
- R3: Under policy code 2 (threshold), every thread gets a cap of min(pct,100) times ENTRIES divided by 100, truncated. If exactly one thread is set in the registered mask, that thread instead gets ENTRIES.
- R4: The active mask is registered, so a change in the mask alters the caps in the cycle after the clock edge that captures it.
- R5: A thread's free output is its cap minus its occupancy, held at 0 when occupancy is at or above the cap. The thread's full flag is set when its free output is 0. A lowered cap never reduces occupancy.
- R6: The global free count always equals ENTRIES minus the sum of the thread occupancies, and the queue-full flag is set when that count is 0.
- R7: In one cycle, an allocate pulse is granted if its thread is not full and at least one global entry is left after the grants to lower-numbered threads. A pulse that is not granted sets that thread's reject bit combinationally in the same cycle and leaves its occupancy unchanged.
- R8: A release pulse lowers the thread's occupancy by one. A release pulse at zero occupancy is ignored. A granted allocate and a release on the same thread in the same cycle leave its occupancy unchanged.
- R9: Synchronous active-low reset clears every occupancy and the registered mask. The global free count then reads ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | NUM_THR | Per-thread allocate pulse |
| release_req | input | NUM_THR | Per-thread release pulse |
| active_mask | input | NUM_THR | Threads currently running |
| policy | input | 2 | 0 dynamic, 1 partition, 2 threshold, 3 as dynamic |
| thresh_pct | input | 7 | Threshold percentage, values above 100 saturate |
| free_total | output | CW | Global free entries |
| thr_free | output | NUM_THR*CW | Per-thread remaining headroom, thread i at bits [i*CW +: CW] |
| thr_full | output | NUM_THR | Per-thread full flag |
| queue_full | output | 1 | Global full flag |
| alloc_reject | output | NUM_THR | Allocate pulse not granted this cycle |

## Verification
The hardest state to reach is a thread whose occupancy sits above its cap. It only arises after the thread fills a large partition share and the mask then widens, so that the share shrinks. The stimulus grows thread 0 to 12 entries while two threads are active, then activates all four. It checks that the thread's headroom reads zero while its occupancy is kept, and that headroom returns only after enough releases. Global exhaustion under simultaneous requests from several threads is reached by flooding all four allocate pulses under the dynamic policy until the queue fills, so that the priority order decides which threads are granted.

// File: rtl/iq_share_pkg.sv
// Package: shared policy encoding for the issue-queue share limiter.
// Assumes: the policy select is two bits wide; code 3 is treated as dynamic.
package iq_share_pkg;
    typedef enum logic [1:0] {
        POL_DYNAMIC   = 2'd0,
        POL_PARTITION = 2'd1,
        POL_THRESHOLD = 2'd2,
        POL_SPARE     = 2'd3
    } share_pol_e;
endpackage

// File: rtl/iq_cap_calc.sv
// Module: works out the per-thread entry cap from the policy, the registered
// active mask and the threshold percentage. Purely combinational.
// Assumes: ENTRIES * 100 fits in 32 bits.
module iq_cap_calc
    import iq_share_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int ENTRIES = 32,
    parameter int CW      = $clog2(ENTRIES + 1)
) (
    input  logic [NUM_THR-1:0]         mask_q,
    input  logic [1:0]                 policy,
    input  logic [6:0]                 thresh_pct,
    output logic [NUM_THR-1:0][CW-1:0] caps
);
    localparam int BASE_SHARE = ENTRIES / NUM_THR;

    int unsigned act_cnt;
    int unsigned pct_sat;
    int unsigned thr_cap;
    int unsigned part_cap;

    // Purpose: count active threads and derive the shared cap values.
    always_comb begin
        act_cnt = 0;
        for (int i = 0; i < NUM_THR; i++) begin
            act_cnt = act_cnt + {31'd0, mask_q[i]};
        end
        pct_sat  = (thresh_pct > 7'd100) ? 100 : {25'd0, thresh_pct};
        thr_cap  = (pct_sat * ENTRIES) / 100;
        part_cap = (act_cnt == 0) ? BASE_SHARE : (ENTRIES / act_cnt);
    end

    // Purpose: pick each thread's cap according to the selected policy.
    always_comb begin
        for (int i = 0; i < NUM_THR; i++) begin
            unique case (share_pol_e'(policy))
                POL_PARTITION: caps[i] = mask_q[i] ? CW'(part_cap) : CW'(BASE_SHARE);
                POL_THRESHOLD: caps[i] = (mask_q[i] && act_cnt == 1) ? CW'(ENTRIES)
                                                                     : CW'(thr_cap);
                default:       caps[i] = CW'(ENTRIES);
            endcase
        end
    end
endmodule

// File: rtl/iq_alloc_arb.sv
// Module: grants allocate pulses in thread-index order, lowest first, within
// each thread's own headroom and the remaining global headroom.
// Assumes: free_total is the global count at the start of the cycle.
module iq_alloc_arb #(
    parameter int NUM_THR = 4,
    parameter int CW      = 6
) (
    input  logic [NUM_THR-1:0] alloc_req,
    input  logic [NUM_THR-1:0] thr_full,
    input  logic [CW-1:0]      free_total,
    output logic [NUM_THR-1:0] grant
);
    logic [CW-1:0] remain;

    // Purpose: walk the threads in priority order, consuming global room.
    always_comb begin
        remain = free_total;
        grant  = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (alloc_req[i] && !thr_full[i] && remain != '0) begin
                grant[i] = 1'b1;
                remain   = remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_thread_ctr.sv
// Module: occupancy counter for one thread, with its headroom and full flag.
// Assumes: a grant is only given while the thread has headroom.
module iq_thread_ctr #(
    parameter int ENTRIES = 32,
    parameter int CW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant,
    input  logic          release_req,
    input  logic [CW-1:0] cap,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] free,
    output logic          full,
    output logic          rel_ok
);
    // Purpose: a release only counts when the thread holds an entry.
    assign rel_ok = release_req && (occ != '0);

    // Purpose: update the occupancy from this cycle's grant and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (grant && !rel_ok) begin
            occ <= occ + 1'b1;
        end else if (!grant && rel_ok) begin
            occ <= occ - 1'b1;
        end
    end

    // Purpose: headroom saturates at zero when the cap is below occupancy.
    always_comb begin
        free = (cap > occ) ? (cap - occ) : '0;
        full = (free == '0);
    end

    assert_occ_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(ENTRIES));

    assert_no_grant_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !grant);

    assert_release_at_zero_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && !grant) |=> (occ == '0));
endmodule

// File: rtl/iq_share_limiter.sv
// Module: top of the issue-queue share limiter. Registers the active mask,
// keeps the global free count and ties the cap, arbiter and counters together.
// Assumes: NUM_THR >= 1 and ENTRIES >= NUM_THR.
module iq_share_limiter #(
    parameter int NUM_THR = 4,
    parameter int ENTRIES = 32,
    parameter int CW      = $clog2(ENTRIES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_THR-1:0]    alloc_req,
    input  logic [NUM_THR-1:0]    release_req,
    input  logic [NUM_THR-1:0]    active_mask,
    input  logic [1:0]            policy,
    input  logic [6:0]            thresh_pct,
    output logic [CW-1:0]         free_total,
    output logic [NUM_THR*CW-1:0] thr_free,
    output logic [NUM_THR-1:0]    thr_full,
    output logic                  queue_full,
    output logic [NUM_THR-1:0]    alloc_reject
);
    logic [NUM_THR-1:0]         mask_q;
    logic [NUM_THR-1:0][CW-1:0] caps;
    logic [NUM_THR-1:0][CW-1:0] occ;
    logic [NUM_THR-1:0]         grant;
    logic [NUM_THR-1:0]         rel_ok;
    logic [CW-1:0]              free_q;
    int unsigned                n_grant;
    int unsigned                n_rel;
    int unsigned                occ_sum;

    // Purpose: capture the active mask; caps follow it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= active_mask;
    end

    iq_cap_calc #(.NUM_THR(NUM_THR), .ENTRIES(ENTRIES), .CW(CW)) u_cap (
        .mask_q     (mask_q),
        .policy     (policy),
        .thresh_pct (thresh_pct),
        .caps       (caps)
    );

    iq_alloc_arb #(.NUM_THR(NUM_THR), .CW(CW)) u_arb (
        .alloc_req  (alloc_req),
        .thr_full   (thr_full),
        .free_total (free_q),
        .grant      (grant)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        iq_thread_ctr #(.ENTRIES(ENTRIES), .CW(CW)) u_ctr (
            .clk         (clk),
            .rst_n       (rst_n),
            .grant       (grant[t]),
            .release_req (release_req[t]),
            .cap         (caps[t]),
            .occ         (occ[t]),
            .free        (thr_free[t*CW +: CW]),
            .full        (thr_full[t]),
            .rel_ok      (rel_ok[t])
        );
    end

    // Purpose: count this cycle's grants and accepted releases.
    always_comb begin
        n_grant = 0;
        n_rel   = 0;
        occ_sum = 0;
        for (int i = 0; i < NUM_THR; i++) begin
            n_grant = n_grant + {31'd0, grant[i]};
            n_rel   = n_rel + {31'd0, rel_ok[i]};
            occ_sum = occ_sum + {{(32-CW){1'b0}}, occ[i]};
        end
    end

    // Purpose: global free counter kept apart from the per-thread counters.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= CW'(ENTRIES);
        else        free_q <= CW'(int'(free_q) + int'(n_rel) - int'(n_grant));
    end

    assign free_total   = free_q;
    assign queue_full   = (free_q == '0);
    assign alloc_reject = alloc_req & ~grant;

    assert_free_matches_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_q) == ENTRIES - int'(occ_sum));

    assert_grants_fit_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= int'(free_q));
endmodule

// File: tb/sim_iq_share_limiter.sv
module sim_iq_share_limiter;
    localparam int NT = 4;
    localparam int E  = 32;
    localparam int CW = $clog2(E + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] alloc_req = '0, release_req = '0, active_mask = '0;
    logic [1:0] policy = 2'd0;
    logic [6:0] thresh_pct = 7'd0;
    logic [CW-1:0] free_total;
    logic [NT*CW-1:0] thr_free;
    logic [NT-1:0] thr_full, alloc_reject;
    logic queue_full;

    always #10 clk = ~clk;

    iq_share_limiter #(.NUM_THR(NT), .ENTRIES(E)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .release_req(release_req),
        .active_mask(active_mask), .policy(policy), .thresh_pct(thresh_pct),
        .free_total(free_total), .thr_free(thr_free), .thr_full(thr_full),
        .queue_full(queue_full), .alloc_reject(alloc_reject)
    );

    typedef struct {
        int          ft;
        int          tf[NT];
        logic [NT-1:0] tfull;
        logic        qf;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    int occ_m[NT];
    logic [NT-1:0] mask_m;

    // Cap model built from R1..R3.
    function automatic int f_cap(int t, logic [NT-1:0] mk, logic [1:0] pol, int pct);
        int cnt = 0;
        int ps;
        for (int i = 0; i < NT; i++) cnt += mk[i];
        ps = (pct > 100) ? 100 : pct;
        if (pol == 2'd1) return mk[t] ? ((cnt == 0) ? E / NT : E / cnt) : E / NT;
        if (pol == 2'd2) return (mk[t] && cnt == 1) ? E : (ps * E) / 100;
        return E;
    endfunction

    function automatic int f_free(int t, logic [1:0] pol, int pct);
        int c = f_cap(t, mask_m, pol, pct);
        return (c > occ_m[t]) ? c - occ_m[t] : 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check rejects, push expected state.
    task automatic step(logic [NT-1:0] a, logic [NT-1:0] r, logic [NT-1:0] m,
                        logic [1:0] pol, int pct, string tag);
        int gfree;
        logic [NT-1:0] exp_rej;
        exp_t e;
        @(negedge clk);
        alloc_req = a; release_req = r; active_mask = m;
        policy = pol; thresh_pct = 7'(pct);
        #1;
        gfree = E;
        for (int i = 0; i < NT; i++) gfree -= occ_m[i];
        exp_rej = '0;
        for (int i = 0; i < NT; i++) begin
            int d = 0;
            if (a[i] && f_free(i, pol, pct) > 0 && gfree > 0) begin
                gfree--; d++;
            end else if (a[i]) exp_rej[i] = 1'b1;
            if (r[i] && occ_m[i] > 0) d--;
            occ_m[i] += d;
        end
        check({tag, " R7 reject"}, int'(alloc_reject), int'(exp_rej));
        mask_m = m;
        e.ft = E;
        for (int i = 0; i < NT; i++) e.ft -= occ_m[i];
        for (int i = 0; i < NT; i++) begin
            e.tf[i] = f_free(i, pol, pct);
            e.tfull[i] = (e.tf[i] == 0);
        end
        e.qf = (e.ft == 0);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each edge compare outputs with the oldest expected item.
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " R6 free_total"}, int'(free_total), e.ft);
            check({e.tag, " R6 queue_full"}, int'(queue_full), int'(e.qf));
            check({e.tag, " R5 thr_full"}, int'(thr_full), int'(e.tfull));
            for (int i = 0; i < NT; i++)
                check({e.tag, " R5 thr_free"}, int'(thr_free[i*CW +: CW]), e.tf[i]);
        end
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) occ_m[i] = 0;
        mask_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state, R1 dynamic caps
        check("R9 reset free_total", int'(free_total), E);
        check("R9 reset queue_full", int'(queue_full), 0);
        for (int i = 0; i < NT; i++) check("R9 R1 reset thr_free", int'(thr_free[i*CW +: CW]), E);

        // R1/R6/R7: fill thread 0 under dynamic policy
        for (int k = 0; k < E; k++) step(4'b0001, 4'b0000, 4'b0001, 2'd0, 0, "R1 fill");
        step(4'b0010, 4'b0000, 4'b0001, 2'd0, 0, "R7 queue full reject");
        step(4'b0001, 4'b0001, 4'b0001, 2'd3, 0, "R8 alloc+release");
        for (int k = 0; k < E; k++) step(4'b0000, 4'b0001, 4'b0001, 2'd0, 0, "R8 drain");
        step(4'b0000, 4'b0100, 4'b0001, 2'd0, 0, "R8 release at zero");

        // R2/R4: partition with four active threads
        step(4'b0000, 4'b0000, 4'b1111, 2'd1, 0, "R2 four active");
        for (int k = 0; k < 9; k++) step(4'b0001, 4'b0000, 4'b1111, 2'd1, 0, "R2 cap 8");
        step(4'b0000, 4'b0000, 4'b0011, 2'd1, 0, "R4 mask to two");
        for (int k = 0; k < 4; k++) step(4'b0001, 4'b0000, 4'b0011, 2'd1, 0, "R2 cap 16");
        // R5: lowered cap keeps occupancy
        step(4'b0001, 4'b0000, 4'b1111, 2'd1, 0, "R5 cap lowered");
        for (int k = 0; k < 5; k++) step(4'b0000, 4'b0001, 4'b1111, 2'd1, 0, "R5 release over cap");

        // R3: threshold policy
        step(4'b0010, 4'b0000, 4'b1111, 2'd2, 30, "R3 pct 30");
        step(4'b0010, 4'b0000, 4'b1111, 2'd2, 120, "R3 pct saturate");
        step(4'b0000, 4'b0000, 4'b0100, 2'd2, 30, "R3 single active");
        step(4'b0100, 4'b0000, 4'b0100, 2'd2, 30, "R3 single alloc");

        // R7: flood all threads to global exhaustion under dynamic policy
        for (int k = 0; k < 10; k++) step(4'b1111, 4'b0000, 4'b1111, 2'd0, 0, "R7 flood");
        step(4'b1111, 4'b1000, 4'b1111, 2'd0, 0, "R7 R8 full mixed");
        step(4'b0000, 4'b0000, 4'b1111, 2'd0, 0, "R6 settle");

        @(negedge clk);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule